// File: doc/BRIEF.md
# Change-Only-Drive Serial Transmitter with Contention Check

This block sends framed bytes over one shared, bidirectional data wire at one bit per clock. It turns on its pin driver only in a bit-time whose value differs from the bit before it. When a bit repeats, the driver is released and an external keeper holds the wire at its last level. In each released bit-time the block compares the wire with the bit it means to send. A difference shows that another agent is driving the wire. The block then raises a sticky collision flag and abandons the frame.

A user hands in a byte with a valid/ready handshake. The frame starts on the next clock edge and takes one bit-time per clock. With the default parameters, every frame is a 0 start bit, eight data bits with the least significant bit first, an even parity bit, and two 1 stop bits: 12 bit-times in all. Because a frame always ends with two equal stop bits, every frame contains at least one released bit-time, and so at least one contention check. The wire sample can go through an optional synchronizer. The expected bit is then delayed by the same number of stages so that the sample and the expected bit stay aligned.

Top module: `keeper_tx`

## Requirements
- R1: While reset is held and right after it, busy, line_oe and collision are 0, and load_ready is 1.
- R2: After a byte is accepted, line_out presents, one bit per clock, a 0 start bit, then the 8 data bits with bit 0 first, then even parity (XOR of the data bits), then two 1 stop bits.
- R3: During a frame, line_oe is 1 in exactly those bit-times whose bit differs from the previous bit. Before the start bit, the previous bit counts as 1, so the start bit is always driven.
- R4: Whenever busy is 0, line_oe is 0, and a wire level that disagrees with the idle level sets no collision.
- R5: In a released bit-time (busy 1, line_oe 0), a line_in value that differs from line_out sets collision at the next clock edge.
- R6: A line_in value that differs from line_out during a driven bit-time (line_oe 1) has no effect: collision stays 0 and the frame goes on unchanged.
- R7: The clock edge that sets collision also ends the frame: busy and line_oe are 0 from that edge on.
- R8: Once set, collision stays 1 until a cycle with clear_coll high, after which it reads 0.
- R9: load_ready equals the inverse of busy. load_valid raised while busy does not change the frame in progress.
- R10: Without a collision, busy stays 1 for exactly 12 clock cycles after the accepting edge, and then returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_valid | input | 1 | A byte is offered |
| load_data | input | 8 | Byte to send |
| load_ready | output | 1 | A byte can be accepted (high when not busy) |
| line_out | output | 1 | Bit value presented to the pin driver |
| line_oe | output | 1 | Pin driver enable |
| line_in | input | 1 | Level sampled on the shared wire |
| clear_coll | input | 1 | Clears the sticky collision flag |
| collision | output | 1 | Sticky contention flag |
| busy | output | 1 | A frame is in progress |

## Verification
A wrong shift register or bit counter shows up at once on line_out, in the same bit-time, and a wrong frame length shows up on busy at the twelfth edge. A wrong previous-bit register shows up as line_oe that is either missing or extra on the next bit. This is checked for all 256 byte values. A bad comparison or enable path in the checker shows up one edge after a forced mismatch: collision either fails to rise in a released bit-time, or rises in a driven or idle one. Forced mismatches are therefore placed at every bit position for several byte patterns.

// File: rtl/keeper_tx_pkg.sv
package keeper_tx_pkg;

   localparam int PAR_NONE = 0;
   localparam int PAR_EVEN = 1;
   localparam int PAR_ODD  = 2;

   // number of bit-times in one frame
   function automatic int frame_bits(input int dw, input int pm, input int sb);
      return 1 + dw + ((pm == PAR_NONE) ? 0 : 1) + sb;
   endfunction

endpackage

// File: rtl/keeper_tx_framer.sv
module keeper_tx_framer
   import keeper_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PARITY_MODE = PAR_EVEN,
   parameter int STOP_BITS   = 2,
   localparam int FRAME_LEN  = frame_bits(DATA_W, PARITY_MODE, STOP_BITS)
) (
   input  logic [DATA_W-1:0]    data_i,
   output logic [FRAME_LEN-1:0] frame_o   // bit 0 leaves first
);

   generate
      if (PARITY_MODE == PAR_NONE) begin : g_nopar
         assign frame_o = {{STOP_BITS{1'b1}}, data_i, 1'b0};
      end else begin : g_par
         logic par_bit;
         assign par_bit = (^data_i) ^ (PARITY_MODE == PAR_ODD);
         assign frame_o = {{STOP_BITS{1'b1}}, par_bit, data_i, 1'b0};
      end
   endgenerate

endmodule

// File: rtl/keeper_tx_sync.sv
module keeper_tx_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q <= '1;   // idle wire is high
            end else begin
               chain_q[0] <= d_i;
               for (int i = 1; i < STAGES; i++) begin
                  chain_q[i] <= chain_q[i-1];
               end
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/keeper_tx_collide.sv
module keeper_tx_collide #(
   parameter int LAG = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,    // raw wire level
   input  logic exp_i,     // bit the transmitter presents
   input  logic chk_i,     // driver released this bit-time
   input  logic clear_i,
   output logic hit_o,     // mismatch seen this cycle
   output logic flag_o
);

   logic line_s;
   logic exp_al;
   logic chk_al;
   logic flag_q;

   keeper_tx_sync #(.STAGES(LAG)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (line_i),
      .q_o   (line_s)
   );

   // delay the expectation by as many stages as the synchronizer adds
   generate
      if (LAG == 0) begin : g_nodelay
         assign exp_al = exp_i;
         assign chk_al = chk_i;
      end else begin : g_delay
         logic [LAG-1:0] exp_p;
         logic [LAG-1:0] chk_p;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               exp_p <= '1;
               chk_p <= '0;
            end else begin
               exp_p[0] <= exp_i;
               chk_p[0] <= chk_i;
               for (int i = 1; i < LAG; i++) begin
                  exp_p[i] <= exp_p[i-1];
                  chk_p[i] <= chk_p[i-1];
               end
            end
         end
         assign exp_al = exp_p[LAG-1];
         assign chk_al = chk_p[LAG-1];
      end
   endgenerate

   assign hit_o = chk_al & (line_s != exp_al);

   // a fresh mismatch wins over a clear request
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (hit_o) begin
         flag_q <= 1'b1;
      end else if (clear_i) begin
         flag_q <= 1'b0;
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/keeper_tx.sv
module keeper_tx
   import keeper_tx_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int PARITY_MODE = PAR_EVEN,
   parameter int STOP_BITS   = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_valid,
   input  logic [DATA_W-1:0] load_data,
   output logic              load_ready,
   output logic              line_out,
   output logic              line_oe,
   input  logic              line_in,
   input  logic              clear_coll,
   output logic              collision,
   output logic              busy
);

   localparam int FRAME_LEN = frame_bits(DATA_W, PARITY_MODE, STOP_BITS);
   localparam int CNT_W     = $clog2(FRAME_LEN + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

   // parameter guards
   initial begin
      if (DATA_W < 1) $fatal(1, "keeper_tx: DATA_W must be at least 1");
      if (STOP_BITS < 2) $fatal(1, "keeper_tx: STOP_BITS below 2 leaves frames without a check");
      if (PARITY_MODE < PAR_NONE || PARITY_MODE > PAR_ODD)
         $fatal(1, "keeper_tx: PARITY_MODE out of range");
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)
         $fatal(1, "keeper_tx: SYNC_STAGES must be 0..4");
   end

   logic [FRAME_LEN-1:0] frame_w;
   logic [FRAME_LEN-1:0] shreg_q;
   logic [CNT_W-1:0]     cnt_q;
   logic                 busy_q;
   logic                 prev_q;
   logic                 cur_bit;
   logic                 accept;
   logic                 chk_en;
   logic                 hit;

   keeper_tx_framer #(
      .DATA_W      (DATA_W),
      .PARITY_MODE (PARITY_MODE),
      .STOP_BITS   (STOP_BITS)
   ) u_framer (
      .data_i  (load_data),
      .frame_o (frame_w)
   );

   assign cur_bit    = shreg_q[0];
   assign load_ready = ~busy_q;
   assign accept     = load_valid & ~busy_q;
   assign line_out   = busy_q ? cur_bit : prev_q;
   assign line_oe    = busy_q & (cur_bit != prev_q);
   assign chk_en     = busy_q & ~line_oe;

   keeper_tx_collide #(.LAG(SYNC_STAGES)) u_collide (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_i  (line_in),
      .exp_i   (cur_bit),
      .chk_i   (chk_en),
      .clear_i (clear_coll),
      .hit_o   (hit),
      .flag_o  (collision)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         prev_q  <= 1'b1;
         shreg_q <= '1;
         cnt_q   <= '0;
      end else if (hit) begin
         // abandon the frame; the next start bit must be driven
         busy_q  <= 1'b0;
         prev_q  <= 1'b1;
         shreg_q <= '1;
         cnt_q   <= '0;
      end else if (accept) begin
         busy_q  <= 1'b1;
         shreg_q <= frame_w;
         cnt_q   <= '0;
      end else if (busy_q) begin
         prev_q  <= cur_bit;
         shreg_q <= {1'b1, shreg_q[FRAME_LEN-1:1]};
         if (cnt_q == LAST_IDX) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/keeper_tx_checker.sv
module keeper_tx_checker #(
   parameter int SYNC_STAGES = 0
) (
   input logic clk,
   input logic rst_n,
   input logic load_ready,
   input logic line_out,
   input logic line_oe,
   input logic line_in,
   input logic clear_coll,
   input logic collision,
   input logic busy
);

   // R4: driver stays released outside a frame
   assert_idle_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !line_oe);

   // R2, R3: the start bit is 0 and driven
   assert_start_driven_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!line_out && line_oe));

   // R3: driven exactly on a bit change inside a frame
   assert_drive_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (line_oe == (line_out != $past(line_out))));

   // R7: a new collision leaves the block idle and released
   assert_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(collision) |-> (!busy && !line_oe));

   // R8: flag holds without a clear
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (collision && !clear_coll) |=> collision);

   // R9: no acceptance while busy
   assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !load_ready);

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         // R5, R6: a rise needs a released bit-time with a differing wire
         assert_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(collision) |-> ($past(busy) && !$past(line_oe) &&
                                  ($past(line_in) != $past(line_out))));
      end
   endgenerate

endmodule

bind keeper_tx keeper_tx_checker #(.SYNC_STAGES(SYNC_STAGES)) u_keeper_tx_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_ready (load_ready),
   .line_out   (line_out),
   .line_oe    (line_oe),
   .line_in    (line_in),
   .clear_coll (clear_coll),
   .collision  (collision),
   .busy       (busy)
);

// File: tb/keeper_tx_test.sv
`timescale 1ns/1ps
module keeper_tx_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_valid = 1'b0;
   logic [7:0] load_data = 8'h00;
   logic       load_ready;
   logic       line_out;
   logic       line_oe;
   logic       line_in;
   logic       clear_coll = 1'b0;
   logic       collision;
   logic       busy;
   logic       inject = 1'b0;
   logic       held = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   keeper_tx uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_valid (load_valid),
      .load_data  (load_data),
      .load_ready (load_ready),
      .line_out   (line_out),
      .line_oe    (line_oe),
      .line_in    (line_in),
      .clear_coll (clear_coll),
      .collision  (collision),
      .busy       (busy)
   );

   // keeper model: the wire keeps the last driven level
   always @(posedge clk) if (line_oe) held <= line_out;
   assign line_in = (line_oe ? line_out : held) ^ inject;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // inj: bit position to disturb (-1 none); poke: offer another byte while busy
   task automatic send(input logic [7:0] d, input int inj, input bit poke);
      logic fb [12];
      logic prev;
      bit   aborted;
      fb[0] = 1'b0;
      for (int i = 0; i < 8; i++) fb[i+1] = d[i];
      fb[9]  = ^d;
      fb[10] = 1'b1;
      fb[11] = 1'b1;
      prev = 1'b1;
      aborted = 1'b0;
      check(load_ready == 1'b1, "R9 ready before load", int'(load_ready), 1);
      load_valid = 1'b1;
      load_data  = d;
      tick();
      if (poke) load_data = ~d; else load_valid = 1'b0;
      for (int k = 0; k < 12; k++) begin
         if (k == 2) load_valid = 1'b0;
         inject = (k == inj);
         #1;
         check(busy && line_out == fb[k] && line_oe == (fb[k] != prev),
               (line_out != fb[k]) ? "R2 bit value" : "R3 drive enable",
               {busy, line_out, line_oe}, {1'b1, fb[k], fb[k] != prev});
         if (poke && k < 2)
            check(load_ready == 1'b0, "R9 not ready while busy", int'(load_ready), 0);
         tick();
         inject = 1'b0;
         if (k == inj) begin
            if (fb[k] == prev) begin
               check(collision == 1'b1, "R5 released mismatch flagged", int'(collision), 1);
               check(!busy && !line_oe, "R7 abort releases", {busy, line_oe}, 0);
               aborted = 1'b1;
               break;
            end else begin
               check(collision == 1'b0, "R6 driven mismatch ignored", int'(collision), 0);
            end
         end
         prev = fb[k];
      end
      if (aborted) begin
         repeat (3) tick();
         check(collision == 1'b1, "R8 flag sticky", int'(collision), 1);
         clear_coll = 1'b1;
         tick();
         clear_coll = 1'b0;
         check(collision == 1'b0, "R8 flag cleared", int'(collision), 0);
      end else begin
         check(!busy && load_ready, "R10 frame length 12", int'(busy), 0);
         check(!line_oe && !collision, "R4 idle released", {line_oe, collision}, 0);
         tick();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !line_oe && !collision && load_ready, "R1 reset state",
            {busy, line_oe, collision, load_ready}, 1);
      rst_n = 1'b1;
      tick();
      check(!busy && !line_oe && !collision && load_ready, "R1 after reset",
            {busy, line_oe, collision, load_ready}, 1);

      // R4: disturbed idle wire sets nothing
      inject = 1'b1;
      repeat (3) tick();
      inject = 1'b0;
      check(!collision && !line_oe, "R4 idle mismatch ignored", {collision, line_oe}, 0);

      // R2 R3 R10: every byte value, clean wire
      for (int b = 0; b < 256; b++) send(8'(b), -1, (b % 37) == 5);

      // R5 R6 R7 R8: disturbance at every bit position
      for (int p = 0; p < 4; p++) begin
         logic [7:0] pat;
         case (p)
            0: pat = 8'h00;
            1: pat = 8'h55;
            2: pat = 8'hA3;
            default: pat = 8'hFF;
         endcase
         for (int k = 0; k < 12; k++) send(pat, k, 1'b0);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule